// File: doc/BRIEF.md
# Bus Break Condition Matcher

This block is a single-channel hardware breakpoint comparator. Each clock it looks at one bus cycle, given as an address with a valid strobe and a set of attribute signals. The attributes are the bus the cycle ran on, the bus master, fetch or data access, read or write, and operand size. When the cycle meets a programmed condition, the block raises a one-cycle break request on the next clock. It also latches the hit into a sticky status flag.

Software sets up the condition through a small 32-bit register port. Word 0 holds the compare address. Word 1 holds a per-bit address mask, where a 1 drops that bit from the compare. Word 2 is the cycle condition register. Word 3 holds the sticky hit flag in bit 0. The condition register carries a multi-hot master filter. That filter applies only to cycles on the internal bus, and when it is all zero no internal-bus cycle can match.

A small state machine produces the break pulse. It has two states:
- `BRK_IDLE`: no pulse is driven.
- `BRK_FIRE`: the pulse is driven.

It has four transitions:
- IDLE→FIRE when the current cycle hits.
- FIRE→FIRE when the next cycle also hits.
- FIRE→IDLE when the next cycle does not hit.
- IDLE→IDLE when there is no hit.

Top module: `brk_cond_match`

## Requirements
- R1: After reset, all four register words read 0 and `brk_pulse` is 0.
- R2: Register words 0 (compare address) and 1 (address mask) store and read back all 32 bits written.
- R3: Word 2 stores only bits 10:0; bits 31:11 always read 0 and ignore writes.
- R4: A cycle's address agrees when every bit whose mask bit is 0 equals the compare address bit; bits with mask bit 1 are not compared.
- R5: Word 2 bits 10:8 form a multi-hot master filter for internal-bus cycles: bit 8 admits master code 0 (CPU), bit 9 admits code 1 (DMA controller), bit 10 admits code 2 (transfer controller); the value 000 means no internal-bus cycle ever matches.
- R6: For cycles on the local CPU bus (`bus_is_local`=1) the master filter is ignored.
- R7: Bus type field, word 2 bits 7:6: 00 means no comparison, 01 means local bus only, 10 means internal bus only, and 11 means either.
- R8: Access kind field, word 2 bits 5:4: 00 means no comparison, 01 means fetch only (`bus_is_data`=0), 10 means data only, and 11 means either.
- R9: Direction field, word 2 bits 3:2: 00 means no comparison, 01 means read only (`bus_is_write`=0), 10 means write only, and 11 means either.
- R10: Size field, word 2 bits 1:0: 00 means no comparison; otherwise the cycle's `bus_size` must equal it (01 byte, 10 word, 11 longword).
- R11: `brk_pulse` is 1 in exactly the clock after a cycle with `bus_valid`=1 where address and every field agree, and is 0 otherwise; back-to-back hits give back-to-back pulses.
- R12: Word 3 bit 0 is set by every hit (same edge as the pulse), cleared by writing bit 0 as 0 to word 3, unchanged by writing 1, and a hit in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Monitored cycle is present |
| bus_addr | input | 32 | Monitored cycle address |
| bus_is_local | input | 1 | 1 = local CPU bus, 0 = internal bus |
| bus_master | input | 2 | Master code: 0 CPU, 1 DMA controller, 2 transfer controller |
| bus_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_is_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| brk_pulse | output | 1 | Registered one-cycle break request |

## Verification
The assertions assume a few things about the monitored cycle. The attribute inputs are stable and meaningful whenever `bus_valid` is high. `bus_master` carries one of the three defined codes. `bus_size` is never 00.

The stimulus stays inside these assumptions. It sweeps master codes 0 to 2 and sizes 01 to 11 only. It holds `bus_valid` low while the condition registers are rewritten, so no hit is ever judged against a half-programmed condition.

The sweeps cover every value of the bus type, access kind, direction and size fields against every legal cycle. They also pair all eight master filter values with both bus types. The address path is checked separately with walking single-bit differences under several mask patterns.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int unsigned MASTER_N  = 3;
    localparam int unsigned FIELD_W   = 2;
    localparam int unsigned COND_W    = MASTER_N + 4 * FIELD_W;
    localparam int unsigned REG_WORDS = 4;
    localparam int unsigned RADDR_W   = $clog2(REG_WORDS);

    localparam logic [RADDR_W-1:0] W_CMP  = 2'd0;
    localparam logic [RADDR_W-1:0] W_MASK = 2'd1;
    localparam logic [RADDR_W-1:0] W_COND = 2'd2;
    localparam logic [RADDR_W-1:0] W_STAT = 2'd3;

    typedef struct packed {
        logic [MASTER_N-1:0] master_sel;
        logic [FIELD_W-1:0]  bus_kind;
        logic [FIELD_W-1:0]  access_kind;
        logic [FIELD_W-1:0]  direction;
        logic [FIELD_W-1:0]  size;
    } cond_t;

    typedef enum logic [0:0] {
        BRK_IDLE = 1'b0,
        BRK_FIRE = 1'b1
    } brk_state_t;

    function automatic logic two_way_ok(input logic [FIELD_W-1:0] fld,
                                        input logic second);
        if (fld == '0) return 1'b1;
        return second ? fld[1] : fld[0];
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata,
    input  logic               set_hit,
    output logic [AW-1:0]      cmp_addr,
    output logic [AW-1:0]      cmp_mask,
    output cond_t              cond
);

    logic  sticky_q;
    logic  clr_hit;
    cond_t cond_q;

    assign clr_hit = reg_we && (reg_addr == W_STAT) && !reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_addr <= '0;
            cmp_mask <= '0;
            cond_q   <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                W_CMP:   cmp_addr <= reg_wdata;
                W_MASK:  cmp_mask <= reg_wdata;
                W_COND:  cond_q   <= cond_t'(reg_wdata[COND_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sticky_q <= 1'b0;
        else if (set_hit) sticky_q <= 1'b1;
        else if (clr_hit) sticky_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            W_CMP:   reg_rdata = cmp_addr;
            W_MASK:  reg_rdata = cmp_mask;
            W_COND:  reg_rdata[COND_W-1:0] = cond_q;
            W_STAT:  reg_rdata[0] = sticky_q;
            default: ;
        endcase
    end

    assign cond = cond_q;

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> (reg_addr != W_STAT) || reg_rdata[0]); // R12
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !clr_hit) |=> sticky_q); // R12
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == W_COND) |-> (reg_rdata[AW-1:COND_W] == '0)); // R3

endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] cmp_mask,
    output logic          addr_ok
);

    logic [AW-1:0] bit_ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_ok[i] = cmp_mask[i] | ~(bus_addr[i] ^ cmp_addr[i]);
    end

    assign addr_ok = &bit_ok;

    AST_FULL_MASK_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (&cmp_mask) |-> addr_ok); // R4
    AST_NO_MASK_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_mask == '0) && (bus_addr != cmp_addr)) |-> !addr_ok); // R4

endmodule

// File: rtl/brk_attr_filter.sv
module brk_attr_filter
    import brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cond_t      cond,
    input  logic       bus_is_local,
    input  logic [1:0] bus_master,
    input  logic       bus_is_data,
    input  logic       bus_is_write,
    input  logic [1:0] bus_size,
    output logic       attr_ok
);

    logic [MASTER_N-1:0] admit;
    logic master_ok, kind_ok, access_ok, dir_ok, size_ok;

    for (genvar m = 0; m < MASTER_N; m++) begin : g_master
        assign admit[m] = cond.master_sel[m] && (bus_master == 2'(m));
    end

    always_comb begin
        master_ok = bus_is_local || (|admit);
        kind_ok   = two_way_ok(cond.bus_kind, !bus_is_local);
        access_ok = two_way_ok(cond.access_kind, bus_is_data);
        dir_ok    = two_way_ok(cond.direction, bus_is_write);
        size_ok   = (cond.size == '0) || (cond.size == bus_size);
        attr_ok   = master_ok && kind_ok && access_ok && dir_ok && size_ok;
    end

    AST_NO_MASTER_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_is_local && (cond.master_sel == '0)) |-> !attr_ok); // R5
    AST_SIZE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond.size != '0) && (cond.size != bus_size)) |-> !attr_ok); // R10

endmodule

// File: rtl/brk_pulse_fsm.sv
module brk_pulse_fsm
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_hit,
    output logic brk_pulse
);

    brk_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRK_IDLE: if (bus_hit)  state_d = BRK_FIRE;
            BRK_FIRE: if (!bus_hit) state_d = BRK_IDLE;
            default:  state_d = BRK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        brk_pulse = 1'b0;
        unique case (state_q)
            BRK_IDLE: brk_pulse = 1'b0;
            BRK_FIRE: brk_pulse = 1'b1;
            default:  brk_pulse = 1'b0;
        endcase
    end

    AST_PULSE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |=> brk_pulse); // R11
    AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |=> !brk_pulse); // R11

endmodule

// File: rtl/brk_cond_match.sv
module brk_cond_match
    import brk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata,
    input  logic               bus_valid,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_is_local,
    input  logic [1:0]         bus_master,
    input  logic               bus_is_data,
    input  logic               bus_is_write,
    input  logic [1:0]         bus_size,
    output logic               brk_pulse
);

    logic [AW-1:0] cmp_addr, cmp_mask;
    cond_t         cond;
    logic          addr_ok, attr_ok, bus_hit;

    brk_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_hit(bus_hit),
        .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .cond(cond)
    );

    brk_addr_cmp #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .cmp_addr(cmp_addr), .cmp_mask(cmp_mask),
        .addr_ok(addr_ok)
    );

    brk_attr_filter u_attr (
        .clk(clk), .rst_n(rst_n), .cond(cond),
        .bus_is_local(bus_is_local), .bus_master(bus_master),
        .bus_is_data(bus_is_data), .bus_is_write(bus_is_write),
        .bus_size(bus_size), .attr_ok(attr_ok)
    );

    assign bus_hit = bus_valid && addr_ok && attr_ok;

    brk_pulse_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_hit(bus_hit), .brk_pulse(brk_pulse)
    );

    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !brk_pulse); // R11

endmodule

// File: tb/sim_brk_cond_match.sv
module sim_brk_cond_match;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_is_local = 1'b0;
    logic [1:0]  bus_master = '0;
    logic        bus_is_data = 1'b0;
    logic        bus_is_write = 1'b0;
    logic [1:0]  bus_size = 2'b01;
    logic        brk_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_cmp = '0, m_mask = '0;
    logic [10:0] m_cond = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_cond_match u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 0; reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk); #1;
        reg_we = 0;
        if (a == 2'd0) m_cmp = d;
        if (a == 2'd1) m_mask = d;
        if (a == 2'd2) m_cond = d[10:0];
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic bit pick(input logic [1:0] f, input bit second);
        case (f)
            2'b00: return 1;
            2'b01: return !second;
            2'b10: return second;
            default: return 1;
        endcase
    endfunction

    function automatic bit model_hit(input logic [31:0] a, input bit loc, input logic [1:0] mst,
                                     input bit dat, input bit wrt, input logic [1:0] sz);
        bit ok;
        ok = (((a ^ m_cmp) & ~m_mask) == 32'd0);
        if (!loc) begin
            case (mst)
                2'd0: ok &= m_cond[8];
                2'd1: ok &= m_cond[9];
                2'd2: ok &= m_cond[10];
                default: ok = 0;
            endcase
        end
        ok &= pick(m_cond[7:6], !loc);
        ok &= pick(m_cond[5:4], dat);
        ok &= pick(m_cond[3:2], wrt);
        ok &= (m_cond[1:0] == 2'b00) || (m_cond[1:0] == sz);
        return ok;
    endfunction

    task automatic cyc(input string req, input bit v, input logic [31:0] a, input bit loc,
                       input logic [1:0] mst, input bit dat, input bit wrt, input logic [1:0] sz);
        bit exp;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_is_local = loc; bus_master = mst;
        bus_is_data = dat; bus_is_write = wrt; bus_size = sz;
        exp = v && model_hit(a, loc, mst, dat, wrt, sz);
        @(posedge clk); #1;
        check(req, {31'd0, brk_pulse}, {31'd0, exp});
    endtask

    task automatic sweep_cycles(input string req);
        for (int loc = 0; loc < 2; loc++)
            for (int mst = 0; mst < 3; mst++)
                for (int dat = 0; dat < 2; dat++)
                    for (int wrt = 0; wrt < 2; wrt++)
                        for (int sz = 1; sz < 4; sz++)
                            cyc(req, 1'b1, m_cmp, loc[0], 2'(mst), dat[0], wrt[0], 2'(sz));
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        for (int w = 0; w < 4; w++) rd_check("R1 reset read", 2'(w), 32'd0);
        check("R1 reset pulse", {31'd0, brk_pulse}, 32'd0);

        // R2: full-width storage
        wr(2'd0, 32'hA5C3_0F96); rd_check("R2 cmp", 2'd0, 32'hA5C3_0F96);
        wr(2'd1, 32'h5A3C_F069); rd_check("R2 mask", 2'd1, 32'h5A3C_F069);
        wr(2'd0, 32'hFFFF_FFFF); rd_check("R2 cmp ones", 2'd0, 32'hFFFF_FFFF);

        // R3: reserved bits of condition word
        wr(2'd2, 32'hFFFF_FFFF); rd_check("R3 cond rsv", 2'd2, 32'h0000_07FF);
        wr(2'd2, 32'h0000_F800); rd_check("R3 cond rsv only", 2'd2, 32'h0);

        // R4: masked address compare, walking single-bit differences
        wr(2'd2, 32'h0000_0040);
        for (int p = 0; p < 4; p++) begin
            logic [31:0] mk;
            mk = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF :
                 (p == 2) ? 32'h0000_FFFF : 32'hAAAA_5555;
            wr(2'd0, 32'h1234_5678 ^ (32'(p) << 28));
            wr(2'd1, mk);
            cyc("R4 exact", 1'b1, m_cmp, 1'b1, 2'd0, 1'b0, 1'b0, 2'b11);
            for (int b = 0; b < 32; b++)
                cyc("R4 bit flip", 1'b1, m_cmp ^ (32'd1 << b), 1'b1, 2'd0, 1'b0, 1'b0, 2'b11);
        end
        wr(2'd1, 32'h0);

        // R7 R8 R9 R10 R11: every field value against every legal cycle
        for (int c = 0; c < 256; c++) begin
            wr(2'd2, {21'd0, 3'b111, 8'(c)});
            sweep_cycles("R7 R8 R9 R10 R11 field sweep");
        end

        // R5 R6: all master filter values on both buses
        for (int ms = 0; ms < 8; ms++)
            for (int bk = 0; bk < 4; bk++) begin
                wr(2'd2, {21'd0, 3'(ms), 2'(bk), 6'd0});
                sweep_cycles("R5 R6 master sweep");
            end

        // R11: invalid cycle never pulses
        wr(2'd2, 32'h0000_0700);
        cyc("R11 invalid", 1'b0, m_cmp, 1'b0, 2'd0, 1'b0, 1'b0, 2'b01);
        cyc("R11 invalid local", 1'b0, m_cmp, 1'b1, 2'd0, 1'b0, 1'b0, 2'b01);

        // R12: sticky flag behaviour
        wr(2'd3, 32'h0); rd_check("R12 cleared", 2'd3, 32'h0);
        cyc("R12 hit", 1'b1, m_cmp, 1'b1, 2'd0, 1'b0, 1'b0, 2'b10);
        @(negedge clk) bus_valid = 0;
        rd_check("R12 set", 2'd3, 32'h1);
        wr(2'd3, 32'h1); rd_check("R12 write one keeps", 2'd3, 32'h1);
        wr(2'd3, 32'h0); rd_check("R12 clear", 2'd3, 32'h0);
        wr(2'd3, 32'h1); rd_check("R12 write one no set", 2'd3, 32'h0);
        @(negedge clk);
        bus_valid = 1; bus_addr = m_cmp; bus_is_local = 1;
        reg_addr = 2'd3; reg_wdata = 32'h0; reg_we = 1;
        @(posedge clk); #1;
        reg_we = 0;
        check("R12 pulse with clear", {31'd0, brk_pulse}, 32'd1);
        @(negedge clk) bus_valid = 0;
        rd_check("R12 set beats clear", 2'd3, 32'h1);

        done = 1;
        summary();
        $finish;
    end

endmodule